// File: doc/BRIEF.md
# Load/Store Effective Address Generator with Alignment Trap

This block forms the effective address of every data memory access issued by a 32-bit core with 16-bit instructions. Each cycle it takes an addressing-mode select, an access size, a direction flag, the candidate base values (two general registers, the index register, the global base register and the program counter) and two short displacements. It returns the address, the updated base value for the auto-modifying modes, and a memory request strobe.

The same cycle's address is tested against the access size. A misaligned access raises a registered exception pulse one cycle later. The pulse carries a direction-dependent code and the address that faulted. When a fault is flagged, the strobe and every base update are withheld, so the core sees no side effect of the failed access. A dual-operand mode serves multiply-accumulate operand fetches. It produces two addresses and two post-incremented bases in one cycle.

Top module: `lsu_addr_gen`

## Requirements
- R1: Size codes are 0 = byte, 1 = word, 2 = long; code 3 is treated as long. A word address is misaligned when bit 0 is 1. A long address is misaligned when bits 1:0 are non-zero. Byte addresses are never faulted.
- R2: A misaligned read reports code 0x0E0 and a misaligned write reports code 0x100, on the 12-bit `exc_code_o`.
- R3: Mode 7 (fetch) uses the PC as the address and checks it as a word read, whatever the size and direction inputs are. A fault reports 0x0E0.
- R4: Mode 1 (register + disp4) adds disp4 scaled by 1, 2 or 4 for byte, word or long to Rn. Mode 5 (global base + disp8) scales disp8 the same way and adds it to the global base.
- R5: Mode 6 (PC-relative) gives (PC with bits 1:0 cleared) + disp8×4 + 4 for long and PC + disp8×2 + 4 for word. For byte it gives PC + disp8 + 4.
- R6: Mode 3 (pre-decrement) forms Rn minus the access size (1, 2 or 4), checks that new address, and writes it back as the primary base.
- R7: Mode 4 (post-increment) accesses and checks the old Rn, and writes back Rn plus the access size as the primary base. Mode 0 accesses Rn unchanged.
- R8: Mode 2 (indexed) accesses Rn + R0.
- R9: Mode 8 (dual fetch) accesses Rm on `addr_o` and Rn on `addr2_o`, both as reads at the given size. It writes back Rm + size as the primary base and Rn + size as the secondary base. Both addresses are checked.
- R10: On a fault, `mem_req_o`, `prim_base_we_o` and `sec_base_we_o` are all low in that cycle.
- R11: If both dual-fetch addresses are misaligned, exactly one exception is raised, and `exc_addr_o` reports the Rm address.
- R12: `exc_valid_o`, `exc_code_o` and `exc_addr_o` are registered. They appear on the cycle after the faulting request and last one cycle per faulting request.
- R13: Modes 9 to 15 are reserved. They produce no strobe, no base update and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | An access is presented this cycle |
| mode_i | input | 4 | Addressing mode select |
| size_i | input | 2 | Access size code |
| is_write_i | input | 1 | 1 = store, 0 = load |
| rn_i | input | 32 | Rn register value |
| rm_i | input | 32 | Rm register value |
| r0_i | input | 32 | Index register value |
| gbr_i | input | 32 | Global base register value |
| pc_i | input | 32 | Program counter of the instruction |
| disp4_i | input | 4 | Short unsigned displacement |
| disp8_i | input | 8 | Long unsigned displacement |
| addr_o | output | 32 | Effective (primary) address |
| addr2_o | output | 32 | Second address, dual mode only |
| prim_base_o | output | 32 | Updated primary base value |
| prim_base_we_o | output | 1 | Primary base write enable |
| sec_base_o | output | 32 | Updated secondary base value (dual) |
| sec_base_we_o | output | 1 | Secondary base write enable |
| mem_req_o | output | 1 | Memory request strobe |
| exc_valid_o | output | 1 | Address-error exception pulse |
| exc_code_o | output | 12 | Exception code |
| exc_addr_o | output | 32 | Faulting address |

## Verification
A wrong scaling or rounding choice shows at once on `addr_o` in the same cycle as the request. For this reason every request is compared combinationally against an independently computed address and base. A wrong alignment decision shows in two places. In the same cycle a strobe or base write appears where none is allowed, or goes missing where one is expected. On the following cycle the registered exception pulse, its code or its faulting address is wrong. The scoreboard queue pairs each request with that next-cycle exception state, so a stuck or stretched pulse is caught on the first cycle it lingers.

// File: rtl/lsu_ag_pkg.sv
// Package: shared encodings for the load/store address generator.
// Assumes a byte-addressed space; the codes match the block's brief.
package lsu_ag_pkg;
    localparam int ADDR_W = 32;
    localparam int CODE_W = 12;

    localparam logic [3:0] AM_IND     = 4'd0;
    localparam logic [3:0] AM_DISP    = 4'd1;
    localparam logic [3:0] AM_IDX     = 4'd2;
    localparam logic [3:0] AM_PREDEC  = 4'd3;
    localparam logic [3:0] AM_POSTINC = 4'd4;
    localparam logic [3:0] AM_GBR     = 4'd5;
    localparam logic [3:0] AM_PCREL   = 4'd6;
    localparam logic [3:0] AM_FETCH   = 4'd7;
    localparam logic [3:0] AM_DUAL    = 4'd8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    localparam logic [CODE_W-1:0] CODE_RD = 12'h0E0;
    localparam logic [CODE_W-1:0] CODE_WR = 12'h100;
endpackage

// File: rtl/lsu_ag_calc.sv
// Module: address arithmetic for all addressing modes.
// Purely combinational. Produces up to two addresses, the written-back
// bases and their enables, and the size/direction the checker must use.
// Assumes displacements are unsigned and already extracted.
module lsu_ag_calc
    import lsu_ag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [3:0]    mode_i,
    input  logic [1:0]    size_i,
    input  logic          is_write_i,
    input  logic [AW-1:0] rn_i,
    input  logic [AW-1:0] rm_i,
    input  logic [AW-1:0] r0_i,
    input  logic [AW-1:0] gbr_i,
    input  logic [AW-1:0] pc_i,
    input  logic [3:0]    disp4_i,
    input  logic [7:0]    disp8_i,
    output logic [AW-1:0] addr_a_o,
    output logic [AW-1:0] addr_b_o,
    output logic [AW-1:0] base_a_o,
    output logic [AW-1:0] base_b_o,
    output logic          base_a_wr_o,
    output logic          base_b_wr_o,
    output logic          use_b_o,
    output logic [1:0]    chk_size_o,
    output logic          chk_write_o,
    output logic          mode_ok_o
);
    logic [1:0]    shift;
    logic [AW-1:0] step;
    logic [AW-1:0] d4s;
    logic [AW-1:0] d8s;
    logic [AW-1:0] pc_round;

    // Size to shift amount and byte step
    always_comb begin
        case (size_i)
            SZ_BYTE: shift = 2'd0;
            SZ_WORD: shift = 2'd1;
            default: shift = 2'd2;
        endcase
        step     = AW'(1) << shift;
        d4s      = AW'(disp4_i) << shift;
        d8s      = AW'(disp8_i) << shift;
        pc_round = (shift == 2'd2) ? {pc_i[AW-1:2], 2'b00} : pc_i;
    end

    // Per-mode address, base update and check parameters
    always_comb begin
        addr_a_o    = rn_i;
        addr_b_o    = '0;
        base_a_o    = rn_i;
        base_b_o    = rn_i;
        base_a_wr_o = 1'b0;
        base_b_wr_o = 1'b0;
        use_b_o     = 1'b0;
        chk_size_o  = size_i;
        chk_write_o = is_write_i;
        mode_ok_o   = 1'b1;
        case (mode_i)
            AM_IND:  addr_a_o = rn_i;
            AM_DISP: addr_a_o = rn_i + d4s;
            AM_IDX:  addr_a_o = rn_i + r0_i;
            AM_PREDEC: begin
                addr_a_o    = rn_i - step;
                base_a_o    = rn_i - step;
                base_a_wr_o = 1'b1;
            end
            AM_POSTINC: begin
                addr_a_o    = rn_i;
                base_a_o    = rn_i + step;
                base_a_wr_o = 1'b1;
            end
            AM_GBR:   addr_a_o = gbr_i + d8s;
            AM_PCREL: addr_a_o = pc_round + d8s + AW'(4);
            AM_FETCH: begin
                addr_a_o    = pc_i;
                chk_size_o  = SZ_WORD;
                chk_write_o = 1'b0;
            end
            AM_DUAL: begin
                addr_a_o    = rm_i;
                addr_b_o    = rn_i;
                base_a_o    = rm_i + step;
                base_b_o    = rn_i + step;
                base_a_wr_o = 1'b1;
                base_b_wr_o = 1'b1;
                use_b_o     = 1'b1;
                chk_write_o = 1'b0;
            end
            default: mode_ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsu_ag_align.sv
// Module: alignment test of one address against one access size.
// Combinational; byte never faults, word needs bit 0 clear,
// long (and the reserved size code) needs bits 1:0 clear.
module lsu_ag_align
    import lsu_ag_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    size_i,
    output logic          mis_o
);
    // Low-bit test selected by size
    always_comb begin
        case (size_i)
            SZ_BYTE: mis_o = 1'b0;
            SZ_WORD: mis_o = addr_i[0];
            default: mis_o = |addr_i[1:0];
        endcase
    end
endmodule

// File: rtl/lsu_ag_exc.sv
// Module: exception output register.
// Captures a fault pulse with its code and address; one cycle per fault.
// Assumes the caller already gated the fault with the request valid.
module lsu_ag_exc
    import lsu_ag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_i,
    input  logic [CW-1:0] code_i,
    input  logic [AW-1:0] addr_i,
    output logic          exc_valid_o,
    output logic [CW-1:0] exc_code_o,
    output logic [AW-1:0] exc_addr_o
);
    // Register the exception pulse, code and faulting address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid_o <= 1'b0;
            exc_code_o  <= '0;
            exc_addr_o  <= '0;
        end else begin
            exc_valid_o <= fault_i;
            if (fault_i) begin
                exc_code_o <= code_i;
                exc_addr_o <= addr_i;
            end
        end
    end
endmodule

// File: rtl/lsu_addr_gen.sv
// Module: load/store effective address generator with alignment trap.
// Combines the mode arithmetic, two alignment checkers and the exception
// register. Strobe and base write-backs are gated off on any fault.
// In dual mode the Rm operand takes priority for the reported address.
module lsu_addr_gen
    import lsu_ag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int CW = CODE_W,
    parameter logic [CW-1:0] RD_CODE = CODE_RD,
    parameter logic [CW-1:0] WR_CODE = CODE_WR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [3:0]    mode_i,
    input  logic [1:0]    size_i,
    input  logic          is_write_i,
    input  logic [AW-1:0] rn_i,
    input  logic [AW-1:0] rm_i,
    input  logic [AW-1:0] r0_i,
    input  logic [AW-1:0] gbr_i,
    input  logic [AW-1:0] pc_i,
    input  logic [3:0]    disp4_i,
    input  logic [7:0]    disp8_i,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] addr2_o,
    output logic [AW-1:0] prim_base_o,
    output logic          prim_base_we_o,
    output logic [AW-1:0] sec_base_o,
    output logic          sec_base_we_o,
    output logic          mem_req_o,
    output logic          exc_valid_o,
    output logic [CW-1:0] exc_code_o,
    output logic [AW-1:0] exc_addr_o
);
    localparam int NOPS = 2;

    logic [AW-1:0] op_addr [NOPS];
    logic [NOPS-1:0] op_mis;
    logic          base_a_wr, base_b_wr, use_b, chk_write, mode_ok;
    logic [1:0]    chk_size;
    logic          active, fault;
    logic [CW-1:0] fault_code;
    logic [AW-1:0] fault_addr;

    lsu_ag_calc #(.AW(AW)) u_calc (
        .mode_i      (mode_i),
        .size_i      (size_i),
        .is_write_i  (is_write_i),
        .rn_i        (rn_i),
        .rm_i        (rm_i),
        .r0_i        (r0_i),
        .gbr_i       (gbr_i),
        .pc_i        (pc_i),
        .disp4_i     (disp4_i),
        .disp8_i     (disp8_i),
        .addr_a_o    (op_addr[0]),
        .addr_b_o    (op_addr[1]),
        .base_a_o    (prim_base_o),
        .base_b_o    (sec_base_o),
        .base_a_wr_o (base_a_wr),
        .base_b_wr_o (base_b_wr),
        .use_b_o     (use_b),
        .chk_size_o  (chk_size),
        .chk_write_o (chk_write),
        .mode_ok_o   (mode_ok)
    );

    // One alignment checker per operand address
    for (genvar g = 0; g < NOPS; g++) begin : g_chk
        lsu_ag_align #(.AW(AW)) u_align (
            .addr_i (op_addr[g]),
            .size_i (chk_size),
            .mis_o  (op_mis[g])
        );
    end

    // Fault decision, priority pick of the reported address, gating
    always_comb begin
        active     = req_valid_i && mode_ok;
        fault      = active && (op_mis[0] || (use_b && op_mis[1]));
        fault_code = chk_write ? WR_CODE : RD_CODE;
        fault_addr = op_mis[0] ? op_addr[0] : op_addr[1];
        mem_req_o      = active && !fault;
        prim_base_we_o = active && !fault && base_a_wr;
        sec_base_we_o  = active && !fault && base_b_wr;
        addr_o         = op_addr[0];
        addr2_o        = op_addr[1];
    end

    lsu_ag_exc #(.AW(AW), .CW(CW)) u_exc (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_i     (fault),
        .code_i      (fault_code),
        .addr_i      (fault_addr),
        .exc_valid_o (exc_valid_o),
        .exc_code_o  (exc_code_o),
        .exc_addr_o  (exc_addr_o)
    );

    // An exception pulse follows a request that was refused its strobe
    assert_exc_after_refused_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> ($past(req_valid_i) && !$past(mem_req_o)));

    // Strobed word accesses are even (fetch aside, it is checked as word anyway)
    assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && size_i == SZ_WORD) |-> !addr_o[0]);

    // Strobed long data accesses sit on a four-byte boundary
    assert_long_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && size_i == SZ_LONG && mode_i != AM_FETCH) |-> (addr_o[1:0] == 2'b00));

    // Only the two defined codes ever appear
    assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> (exc_code_o == RD_CODE || exc_code_o == WR_CODE));

    // Fetch faults always carry the read code
    assert_fetch_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_o && $past(mode_i) == AM_FETCH) |-> (exc_code_o == RD_CODE));

    // Pre-decrement writes back exactly the address it accessed
    assert_predec_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mode_i == AM_PREDEC) |-> (prim_base_we_o && prim_base_o == addr_o));

    // No base update without a strobe
    assert_base_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_base_we_o || sec_base_we_o) |-> mem_req_o);
endmodule

// File: tb/lsu_addr_gen_bench.sv
// Scoreboard bench: the driver computes expected values from the brief,
// checks combinational outputs, and queues the expected exception state
// which the monitor compares on the next cycle.
module lsu_addr_gen_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        vld;
        logic [11:0] code;
        logic [31:0] addr;
        string       tag;
    } exc_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [1:0]  size_i = '0;
    logic        is_write_i = 1'b0;
    logic [31:0] rn_i = '0, rm_i = '0, r0_i = '0, gbr_i = '0, pc_i = '0;
    logic [3:0]  disp4_i = '0;
    logic [7:0]  disp8_i = '0;
    logic [31:0] addr_o, addr2_o, prim_base_o, sec_base_o, exc_addr_o;
    logic        prim_base_we_o, sec_base_we_o, mem_req_o, exc_valid_o;
    logic [11:0] exc_code_o;

    int checks = 0;
    int fails = 0;
    bit started = 0;
    exc_item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_addr_gen u_lsu_addr_gen (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .mode_i(mode_i),
        .size_i(size_i), .is_write_i(is_write_i), .rn_i(rn_i), .rm_i(rm_i),
        .r0_i(r0_i), .gbr_i(gbr_i), .pc_i(pc_i), .disp4_i(disp4_i),
        .disp8_i(disp8_i), .addr_o(addr_o), .addr2_o(addr2_o),
        .prim_base_o(prim_base_o), .prim_base_we_o(prim_base_we_o),
        .sec_base_o(sec_base_o), .sec_base_we_o(sec_base_we_o),
        .mem_req_o(mem_req_o), .exc_valid_o(exc_valid_o),
        .exc_code_o(exc_code_o), .exc_addr_o(exc_addr_o)
    );

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic bit misal(input logic [31:0] a, input logic [1:0] s);
        if (s == 2'd0) return 0;
        if (s == 2'd1) return a[0];
        return a[1:0] != 2'b00;
    endfunction

    // Drive one request for one cycle and check it against the model
    task automatic drive(input bit v, input logic [3:0] m, input logic [1:0] s,
                         input bit w, input logic [31:0] rn, input logic [31:0] rm,
                         input logic [31:0] r0, input logic [31:0] gbr,
                         input logic [31:0] pc, input logic [3:0] d4,
                         input logic [7:0] d8, input string tag);
        logic [31:0] ea, ea2, b1, b2, faddr;
        bit we1, we2, dual, ok, rd, mis, strobe;
        logic [1:0] cs;
        int n;
        exc_item_t it;
        @(negedge clk);
        req_valid_i = v; mode_i = m; size_i = s; is_write_i = w;
        rn_i = rn; rm_i = rm; r0_i = r0; gbr_i = gbr; pc_i = pc;
        disp4_i = d4; disp8_i = d8;
        n = nbytes(s);
        ea = rn; ea2 = 0; b1 = 0; b2 = 0; we1 = 0; we2 = 0; dual = 0;
        ok = 1; rd = !w; cs = s;
        case (m)
            4'd0: ea = rn;
            4'd1: ea = rn + d4 * n;
            4'd2: ea = rn + r0;
            4'd3: begin ea = rn - n; b1 = ea; we1 = 1; end
            4'd4: begin ea = rn; b1 = rn + n; we1 = 1; end
            4'd5: ea = gbr + d8 * n;
            4'd6: ea = (n == 4) ? ((pc & 32'hFFFF_FFFC) + d8 * 4 + 4) : (pc + d8 * n + 4);
            4'd7: begin ea = pc; cs = 2'd1; rd = 1; end
            4'd8: begin ea = rm; ea2 = rn; b1 = rm + n; b2 = rn + n;
                        we1 = 1; we2 = 1; dual = 1; rd = 1; end
            default: ok = 0;
        endcase
        mis = misal(ea, cs) || (dual && misal(ea2, cs));
        mis = mis && v && ok;
        strobe = v && ok && !mis;
        faddr = misal(ea, cs) ? ea : ea2;
        #1;
        checks++;
        if (mem_req_o !== strobe || prim_base_we_o !== (strobe && we1) ||
            sec_base_we_o !== (strobe && we2) ||
            (strobe && addr_o !== ea) ||
            (strobe && dual && addr2_o !== ea2) ||
            (strobe && we1 && prim_base_o !== b1) ||
            (strobe && we2 && sec_base_o !== b2)) begin
            fails++;
            $display("FAIL %s: req=%0b we=%0b/%0b addr=%h addr2=%h base=%h/%h expected req=%0b we=%0b/%0b addr=%h addr2=%h base=%h/%h",
                     tag, mem_req_o, prim_base_we_o, sec_base_we_o, addr_o, addr2_o,
                     prim_base_o, sec_base_o, strobe, strobe && we1, strobe && we2,
                     ea, ea2, b1, b2);
        end
        it.vld = mis;
        it.code = rd ? 12'h0E0 : 12'h100;
        it.addr = faddr;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input string tag);
        drive(0, 4'd0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: compare the registered exception state one cycle later
    always @(negedge clk) begin
        if (started && sb.size() > 0) begin
            exc_item_t e;
            e = sb.pop_front();
            checks++;
            if (exc_valid_o !== e.vld ||
                (e.vld && (exc_code_o !== e.code || exc_addr_o !== e.addr))) begin
                fails++;
                $display("FAIL %s (R12 exception): vld=%0b code=%h addr=%h expected vld=%0b code=%h addr=%h",
                         e.tag, exc_valid_o, exc_code_o, exc_addr_o, e.vld, e.code, e.addr);
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (exc_valid_o !== 1'b0 || mem_req_o !== 1'b0) begin
            fails++;
            $display("FAIL reset (R12): exc=%0b req=%0b expected 0 0", exc_valid_o, mem_req_o);
        end
        started = 1;
        // R1/R7: plain indirect, sizes and alignment
        drive(1, 4'd0, 2'd2, 0, 32'h1000, 0, 0, 0, 0, 0, 0, "R7 ind long ok");
        drive(1, 4'd0, 2'd2, 0, 32'h1002, 0, 0, 0, 0, 0, 0, "R1 long misaligned read");
        drive(1, 4'd0, 2'd1, 1, 32'h1001, 0, 0, 0, 0, 0, 0, "R2 word misaligned write");
        drive(1, 4'd0, 2'd0, 1, 32'h1003, 0, 0, 0, 0, 0, 0, "R1 byte never faults");
        drive(1, 4'd0, 2'd3, 0, 32'h1002, 0, 0, 0, 0, 0, 0, "R1 size3 as long");
        // R4: displacement scaling
        drive(1, 4'd1, 2'd2, 0, 32'h2000, 0, 0, 0, 0, 4'd3, 0, "R4 disp4 long");
        drive(1, 4'd1, 2'd1, 1, 32'h2000, 0, 0, 0, 0, 4'd3, 0, "R4 disp4 word");
        drive(1, 4'd1, 2'd0, 0, 32'h2000, 0, 0, 0, 0, 4'd3, 0, "R4 disp4 byte");
        drive(1, 4'd5, 2'd2, 1, 0, 0, 0, 32'h6000, 0, 0, 8'h10, "R4 gbr long");
        drive(1, 4'd5, 2'd1, 0, 0, 0, 0, 32'h6001, 0, 0, 8'h10, "R4 gbr word fault");
        // R8: indexed
        drive(1, 4'd2, 2'd1, 0, 32'h3000, 0, 32'h10, 0, 0, 0, 0, "R8 indexed ok");
        drive(1, 4'd2, 2'd1, 1, 32'h3000, 0, 32'h11, 0, 0, 0, 0, "R8 indexed write fault");
        // R5: PC-relative rounding
        drive(1, 4'd6, 2'd2, 0, 0, 0, 0, 0, 32'h7002, 0, 8'h01, "R5 pcrel long rounds");
        drive(1, 4'd6, 2'd1, 0, 0, 0, 0, 0, 32'h7002, 0, 8'h01, "R5 pcrel word");
        drive(1, 4'd6, 2'd1, 0, 0, 0, 0, 0, 32'h7001, 0, 8'h01, "R5 pcrel word fault");
        // R6: pre-decrement checks the new address
        drive(1, 4'd3, 2'd2, 1, 32'h4000, 0, 0, 0, 0, 0, 0, "R6 predec long ok");
        drive(1, 4'd3, 2'd2, 1, 32'h4002, 0, 0, 0, 0, 0, 0, "R6 predec long fault");
        drive(1, 4'd3, 2'd1, 1, 32'h4003, 0, 0, 0, 0, 0, 0, "R6 predec word fault");
        drive(1, 4'd3, 2'd1, 0, 32'h4002, 0, 0, 0, 0, 0, 0, "R6 predec word ok");
        // R7: post-increment checks the old address
        drive(1, 4'd4, 2'd2, 0, 32'h5000, 0, 0, 0, 0, 0, 0, "R7 postinc long ok");
        drive(1, 4'd4, 2'd2, 0, 32'h5002, 0, 0, 0, 0, 0, 0, "R7 postinc long fault");
        drive(1, 4'd4, 2'd1, 0, 32'h5006, 0, 0, 0, 0, 0, 0, "R7 postinc word ok");
        // R3: fetch checked as word read
        drive(1, 4'd7, 2'd2, 1, 0, 0, 0, 0, 32'h8001, 0, 0, "R3 fetch odd pc");
        drive(1, 4'd7, 2'd2, 1, 0, 0, 0, 0, 32'h8002, 0, 0, "R3 fetch even pc ok");
        // R9/R11: dual fetch
        drive(1, 4'd8, 2'd2, 1, 32'hA000, 32'h9000, 0, 0, 0, 0, 0, "R9 dual ok");
        drive(1, 4'd8, 2'd2, 1, 32'hA002, 32'h9000, 0, 0, 0, 0, 0, "R9 dual rn fault");
        drive(1, 4'd8, 2'd1, 0, 32'hA001, 32'h9001, 0, 0, 0, 0, 0, "R11 dual both fault");
        drive(1, 4'd8, 2'd1, 0, 32'hA002, 32'h9004, 0, 0, 0, 0, 0, "R9 dual word ok");
        // R13: reserved modes
        drive(1, 4'd12, 2'd2, 0, 32'h1001, 32'h1003, 0, 0, 0, 0, 0, "R13 reserved mode");
        drive(1, 4'd15, 2'd1, 1, 32'h1001, 0, 0, 0, 0, 0, 0, "R13 reserved mode 15");
        // R10/R12: invalid request and back-to-back faults then idle
        drive(0, 4'd0, 2'd2, 0, 32'h1002, 0, 0, 0, 0, 0, 0, "R10 no valid no fault");
        drive(1, 4'd0, 2'd2, 1, 32'h1001, 0, 0, 0, 0, 0, 0, "R12 fault pulse a");
        drive(1, 4'd0, 2'd1, 0, 32'h1003, 0, 0, 0, 0, 0, 0, "R12 fault pulse b");
        idle("R12 pulse ends");
        idle("R12 stays low");
        idle("flush");
        @(negedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule